// File: doc/BRIEF.md
# Interrupt Mask and Priority Register Bank

This block holds the enable masks and the priority levels of an interrupt controller behind a small read/write register bus. Each mask register has two bus addresses: writing to one of them sets the bits given in the data, and writing to the other clears them. Each priority register has one address, and a write there replaces the whole register. The address is decoded on its low 29 bits only, so the upper three address bits choose an alias window and have no effect on which register is selected.

After every accepted write, the block walks the fields of the written register, one field per clock, from the most significant field down to the least. A mask register has one-bit fields. A priority register has fields `PRIO_FW` bits wide. For each field whose value changed, the block raises a one-cycle enable or disable strobe together with that field's source id, which the interrupt logic downstream uses to update its per-source state. A field whose source id is zero is reserved and gives no strobe. Writes that arrive while a walk is in progress are dropped.

Top module: `irq_mask_bank`

## Requirements
- R1: After reset, every register reads 0, `busy` is low, neither strobe is active and `rdata` is 0.
- R2: Only address bits 28:0 take part in decoding. Any value of bits 31:29 reaches the same register.
- R3: Mask register i has its set address at BASE+16*i and its clear address at BASE+16*i+4. Priority register j is at BASE+16*(N_MASK+j). A read of any of these addresses returns the stored value in `rdata` on the cycle after `rd_en` is sampled.
- R4: A write to a mask set address stores old OR wdata.
- R5: A write to a mask clear address stores old AND NOT wdata.
- R6: A write to a priority address stores wdata unchanged.
- R7: An accepted write raises `busy` for exactly NF cycles, starting the cycle after the write edge. NF is DATA_W for a mask register and DATA_W/PRIO_FW for a priority register. In walk cycle k (k = 0 to NF-1), field NF-1-k is examined.
- R8: A field whose old and new values differ, and whose source id is nonzero, gives exactly one strobe in its walk cycle. The strobe is `src_en` if the new field value is nonzero and `src_dis` if it is zero, and `src_id` carries the id. An unchanged field gives no strobe.
- R9: The source id is g+1, where g = i*DATA_W+bit for mask register i, and g = N_MASK*DATA_W + j*(DATA_W/PRIO_FW) + field for priority register j. The id is 0 when bit g of RSVD_MAP is set, and such a field never gives a strobe.
- R10: An access to an unmapped address (this includes BASE+16*(N_MASK+j)+4) reads as 0. A write there changes no register and does not raise `busy`.
- R11: A write presented while `busy` is high changes no register and does not lengthen the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | 32 | Byte address, shared by reads and writes |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| busy | output | 1 | High while the field walk is running |
| src_en | output | 1 | Enable strobe for `src_id` |
| src_dis | output | 1 | Disable strobe for `src_id` |
| src_id | output | SRC_W | Source id of the current strobe |

## Verification
The hardest case to reach from the ports is a write that arrives in the middle of a field walk. The stimulus starts a walk on a mask register and presents a priority write in the next cycle. It waits for `busy` to fall, then reads the priority register back and checks that the walk kept its length. Reserved fields only matter when they actually toggle, so the sweep writes set and clear patterns that flip every mask bit, including the reserved one, and all sixteen values of each priority field. It also changes the alias bits on every write.

// File: rtl/irq_mask_bank_pkg.sv
package irq_mask_bank_pkg;

  typedef enum logic [1:0] {
    MODE_NONE   = 2'd0,
    MODE_OR     = 2'd1,
    MODE_ANDN   = 2'd2,
    MODE_DIRECT = 2'd3
  } wr_mode_e;

  // New register content for a write of d onto cur in mode m.
  function automatic logic [31:0] merge_fn(wr_mode_e m, logic [31:0] cur, logic [31:0] d);
    case (m)
      MODE_OR:     return cur | d;
      MODE_ANDN:   return cur & ~d;
      MODE_DIRECT: return d;
      default:     return cur;
    endcase
  endfunction

  // Field number pos of width fw, counted from the least significant end.
  function automatic logic [31:0] field_of(logic [31:0] v, int unsigned pos, int unsigned fw);
    logic [31:0] m;
    m = (fw >= 32) ? 32'hFFFF_FFFF : ((32'd1 << fw) - 32'd1);
    return (v >> (pos * fw)) & m;
  endfunction

  // Flat field index across the whole bank; priority registers follow the masks.
  function automatic logic [31:0] src_index(logic prio, int unsigned rg, int unsigned pos,
                                            int unsigned nm, int unsigned dw, int unsigned pf);
    if (prio) return 32'((rg - nm) * pf + nm * dw + pos);
    return 32'(rg * dw + pos);
  endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_mask_bank_pkg::*;
#(
  parameter int          N_MASK = 2,
  parameter int          N_PRIO = 2,
  parameter logic [31:0] BASE   = 32'h0400_0000,
  localparam int         NR     = N_MASK + N_PRIO,
  localparam int         IDX_W  = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic [31:0]      addr,
  output logic             hit,
  output logic             is_prio,
  output logic [IDX_W-1:0] idx,
  output wr_mode_e         mode
);
  localparam logic [28:0] BASE_LO = BASE[28:0];
  logic [28:0] a_lo;

  // Upper three bits select an alias window only.
  assign a_lo = addr[28:0];

  always_comb begin
    hit     = 1'b0;
    is_prio = 1'b0;
    idx     = '0;
    mode    = MODE_NONE;
    for (int i = 0; i < N_MASK; i++) begin
      if (a_lo == BASE_LO + 29'(16 * i)) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        mode = MODE_OR;
      end else if (a_lo == BASE_LO + 29'(16 * i + 4)) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        mode = MODE_ANDN;
      end
    end
    for (int j = 0; j < N_PRIO; j++) begin
      if (a_lo == BASE_LO + 29'(16 * (N_MASK + j))) begin
        hit     = 1'b1;
        is_prio = 1'b1;
        idx     = IDX_W'(N_MASK + j);
        mode    = MODE_DIRECT;
      end
    end
  end
endmodule

// File: rtl/irq_reg_store.sv
module irq_reg_store
  import irq_mask_bank_pkg::*;
#(
  parameter int  NR     = 4,
  parameter int  DATA_W = 8,
  localparam int IDX_W  = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_fire,
  input  logic [IDX_W-1:0]   sel_idx,
  input  wr_mode_e           wr_mode,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               rd_en,
  input  logic               rd_hit,
  output logic [DATA_W-1:0]  rdata,
  output logic [DATA_W-1:0]  old_val,
  output logic [DATA_W-1:0]  new_val,
  output logic [NR*DATA_W-1:0] bank_flat
);
  logic [DATA_W-1:0] regs [NR];

  assign old_val = regs[sel_idx];
  assign new_val = DATA_W'(merge_fn(wr_mode, 32'(old_val), 32'(wdata)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) regs[i] <= '0;
    end else if (wr_fire) begin
      regs[sel_idx] <= new_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_hit ? regs[sel_idx] : '0;
  end

  for (genvar g = 0; g < NR; g++) begin : g_flat
    assign bank_flat[g*DATA_W +: DATA_W] = regs[g];
  end

  // R4
  set_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_mode == MODE_OR) |=>
      ((regs[$past(sel_idx)] & $past(old_val)) == $past(old_val)));

  // R5
  clr_drops_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_mode == MODE_ANDN) |=>
      ((regs[$past(sel_idx)] & $past(wdata)) == '0));
endmodule

// File: rtl/irq_field_scanner.sv
module irq_field_scanner
  import irq_mask_bank_pkg::*;
#(
  parameter int          N_MASK   = 2,
  parameter int          N_PRIO   = 2,
  parameter int          DATA_W   = 8,
  parameter int          PRIO_FW  = 4,
  parameter int          SRC_W    = 8,
  parameter logic [63:0] RSVD_MAP = 64'h0,
  localparam int         NR       = N_MASK + N_PRIO,
  localparam int         IDX_W    = (NR > 1) ? $clog2(NR) : 1,
  localparam int         PF       = DATA_W / PRIO_FW,
  localparam int         POS_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_prio,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [DATA_W-1:0] old_in,
  input  logic [DATA_W-1:0] new_in,
  output logic              busy,
  output logic              ev_en,
  output logic              ev_dis,
  output logic [SRC_W-1:0]  ev_src
);
  logic              busy_q;
  logic              prio_q;
  logic [IDX_W-1:0]  reg_q;
  logic [POS_W-1:0]  pos_q;
  logic [DATA_W-1:0] old_q;
  logic [DATA_W-1:0] new_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      prio_q <= 1'b0;
      reg_q  <= '0;
      pos_q  <= '0;
      old_q  <= '0;
      new_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      prio_q <= start_prio;
      reg_q  <= start_idx;
      pos_q  <= start_prio ? POS_W'(PF - 1) : POS_W'(DATA_W - 1);
      old_q  <= old_in;
      new_q  <= new_in;
    end else if (busy_q) begin
      if (pos_q == '0) busy_q <= 1'b0;
      else             pos_q  <= pos_q - 1'b1;
    end
  end

  // Field arithmetic for the field under examination.
  int unsigned       fw;
  logic [31:0]       f_old;
  logic [31:0]       f_new;
  logic [31:0]       gidx;
  logic [SRC_W-1:0]  id_now;
  logic              field_moved;

  assign fw          = prio_q ? PRIO_FW : 1;
  assign f_old       = field_of(32'(old_q), 32'(pos_q), fw);
  assign f_new       = field_of(32'(new_q), 32'(pos_q), fw);
  assign gidx        = src_index(prio_q, 32'(reg_q), 32'(pos_q), N_MASK, DATA_W, PF);
  assign id_now      = RSVD_MAP[gidx[5:0]] ? '0 : SRC_W'(gidx + 32'd1);
  assign field_moved = busy_q && (f_old != f_new) && (id_now != '0);

  assign busy   = busy_q;
  assign ev_en  = field_moved && (f_new != '0);
  assign ev_dis = field_moved && (f_new == '0);
  assign ev_src = id_now;

  // R7
  walk_begins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q);

  // R7
  walk_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && pos_q == '0) |=> !busy_q);
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_mask_bank_pkg::*;
#(
  parameter int          N_MASK   = 2,
  parameter int          N_PRIO   = 2,
  parameter int          DATA_W   = 8,
  parameter int          PRIO_FW  = 4,
  parameter int          SRC_W    = 8,
  parameter logic [31:0] BASE     = 32'h0400_0000,
  parameter logic [63:0] RSVD_MAP = 64'h0000_0000_0002_0008,
  localparam int         NR       = N_MASK + N_PRIO,
  localparam int         IDX_W    = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              src_en,
  output logic              src_dis,
  output logic [SRC_W-1:0]  src_id
);
  logic              dec_hit;
  logic              dec_prio;
  logic [IDX_W-1:0]  dec_idx;
  wr_mode_e          dec_mode;
  logic              wr_fire;
  logic [DATA_W-1:0] old_val;
  logic [DATA_W-1:0] new_val;
  logic [NR*DATA_W-1:0] bank_flat;

  irq_addr_decode #(.N_MASK(N_MASK), .N_PRIO(N_PRIO), .BASE(BASE)) u_dec (
    .addr(addr), .hit(dec_hit), .is_prio(dec_prio), .idx(dec_idx), .mode(dec_mode)
  );

  assign wr_fire = wr_en && dec_hit && !busy;

  irq_reg_store #(.NR(NR), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .sel_idx(dec_idx), .wr_mode(dec_mode),
    .wdata(wdata), .rd_en(rd_en), .rd_hit(dec_hit), .rdata(rdata),
    .old_val(old_val), .new_val(new_val), .bank_flat(bank_flat)
  );

  irq_field_scanner #(
    .N_MASK(N_MASK), .N_PRIO(N_PRIO), .DATA_W(DATA_W), .PRIO_FW(PRIO_FW),
    .SRC_W(SRC_W), .RSVD_MAP(RSVD_MAP)
  ) u_scan (
    .clk(clk), .rst_n(rst_n), .start(wr_fire), .start_prio(dec_prio), .start_idx(dec_idx),
    .old_in(old_val), .new_in(new_val), .busy(busy),
    .ev_en(src_en), .ev_dis(src_dis), .ev_src(src_id)
  );

  // R11
  busy_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> $stable(bank_flat));

  // R10
  unmapped_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !dec_hit && !busy) |=> ($stable(bank_flat) && !busy));

  // R8
  strobe_inside_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en || src_dis) |-> busy);

  // R8
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({src_en, src_dis}));
endmodule

// File: tb/irq_mask_bank_bench.sv
`timescale 1ns/1ps
module irq_mask_bank_bench;
  localparam int NM = 2, NP = 2, DW = 8, FW = 4, PF = DW / FW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy, src_en, src_dis;
  logic [7:0] src_id;

  int checks = 0, errors = 0;
  bit done = 0;
  int model [NM+NP];

  irq_mask_bank u_irq_mask_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .busy(busy), .src_en(src_en), .src_dis(src_dis), .src_id(src_id)
  );

  always #2 clk = ~clk;

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // kind 0: mask set, 1: mask clear, 2: priority, 3: unmapped offset
  function automatic logic [31:0] map_addr(int kind, int i, int win);
    int off;
    case (kind)
      0: off = i * 16;
      1: off = i * 16 + 4;
      2: off = (NM + i) * 16;
      default: off = i;
    endcase
    return (32'h0400_0000 + off) | (32'(win % 8) << 29);
  endfunction

  function automatic int exp_id(bit prio, int rg, int f);
    int g;
    g = prio ? (NM * DW + rg * PF + f) : (rg * DW + f);
    if (g == 3 || g == 17) return 0;
    return g + 1;
  endfunction

  task automatic read_chk(logic [31:0] a, int exp, string req);
    @(negedge clk); rd_en = 1; addr = a;
    @(posedge clk); #1 rd_en = 0;
    @(negedge clk);
    chk(req, rdata, exp, "readback");
  endtask

  task automatic write_walk(int kind, int i, int d, int win);
    int oldv, newv, nf, w, ri;
    bit prio;
    prio = (kind == 2);
    ri = prio ? NM + i : i;
    oldv = model[ri];
    case (kind)
      0: newv = oldv | d;
      1: newv = oldv - (oldv & d);
      default: newv = d;
    endcase
    newv = newv % 256;
    nf = prio ? PF : DW;
    w = prio ? FW : 1;
    @(negedge clk); wr_en = 1; addr = map_addr(kind, i, win); wdata = 8'(d);
    @(posedge clk); #1 wr_en = 0;
    for (int k = 0; k < nf; k++) begin
      int f, fo, fn, id;
      bit exp_en, exp_dis;
      string tag;
      @(negedge clk);
      f  = nf - 1 - k;
      fo = (oldv / (1 << (f * w))) % (1 << w);
      fn = (newv / (1 << (f * w))) % (1 << w);
      id = exp_id(prio, i, f);
      tag = (id == 0) ? "R9" : "R8";
      exp_en  = (fo != fn) && (id != 0) && (fn != 0);
      exp_dis = (fo != fn) && (id != 0) && (fn == 0);
      chk("R7", busy, 1, "busy during walk");
      chk(tag, src_en, exp_en, "enable strobe");
      chk(tag, src_dis, exp_dis, "disable strobe");
      if (exp_en || exp_dis) chk("R9", src_id, id, "source id");
    end
    @(negedge clk);
    chk("R7", busy, 0, "busy after walk");
    model[ri] = newv;
    read_chk(map_addr(kind, i, win + 3), newv, kind == 0 ? "R4" : (kind == 1 ? "R5" : "R6"));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NM + NP; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", busy, 0, "busy in reset");
    chk("R1", src_en | src_dis, 0, "strobe in reset");
    chk("R1", rdata, 0, "rdata in reset");
    rst_n = 1;
    for (int i = 0; i < NM; i++) begin
      read_chk(map_addr(0, i, 0), 0, "R1");
      read_chk(map_addr(1, i, 5), 0, "R3");
    end
    for (int j = 0; j < NP; j++) read_chk(map_addr(2, j, 7), 0, "R1");

    // R2/R4/R5: set/clear sweep with changing alias windows
    for (int r = 0; r < NM; r++) begin
      write_walk(0, r, 8'hFF, r + 1);
      write_walk(1, r, 8'hFF, r + 2);
      for (int k = 0; k < 8; k++) begin
        write_walk(k % 2, r, (k * 37 + r * 11 + 5) % 256, k);
      end
      write_walk(0, r, 8'h08, 6);
      write_walk(1, r, 8'h08, 4);
    end
    // R2: same register reached through every window
    for (int win = 0; win < 8; win++) read_chk(map_addr(0, 1, win), model[1], "R2");

    // R6: every value in each priority field
    for (int j = 0; j < NP; j++)
      for (int v = 0; v < 16; v++) write_walk(2, j, v * 16 + (15 - v), v);
    write_walk(2, 0, 0, 1);

    // R10: unmapped accesses
    read_chk(map_addr(2, 0, 0) + 4, 0, "R10");
    read_chk(map_addr(3, 8'h80, 2), 0, "R10");
    @(negedge clk); wr_en = 1; addr = map_addr(2, 1, 0) + 4; wdata = 8'h5A;
    @(posedge clk); #1 wr_en = 0;
    @(negedge clk);
    chk("R10", busy, 0, "busy after unmapped write");
    chk("R10", src_en | src_dis, 0, "strobe after unmapped write");
    for (int j = 0; j < NP; j++) read_chk(map_addr(2, j, 0), model[NM + j], "R10");

    // R11: write presented in the middle of a walk
    begin
      int cyc;
      @(negedge clk); wr_en = 1; addr = map_addr(1, 0, 0); wdata = 8'hFF;
      @(posedge clk); #1 addr = map_addr(2, 1, 0); wdata = 8'hC3;
      @(posedge clk); #1 wr_en = 0;
      cyc = 1;
      @(negedge clk);
      while (busy && cyc < 40) begin cyc++; @(negedge clk); end
      chk("R11", cyc, DW, "walk length with dropped write");
      @(negedge clk);
      chk("R11", busy, 0, "no second walk");
      model[0] = 0;
      read_chk(map_addr(2, 1, 0), model[NM + 1], "R11");
      read_chk(map_addr(0, 0, 0), 0, "R5");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule